// File: doc/BRIEF.md
# Staggered Split-Width Integer ALU

A pipelined 32-bit integer ALU for the fast clock domain of an execution cluster. It performs add, subtract and the bitwise operations AND, OR and XOR. Each operation is split into two 16-bit halves that are worked on in consecutive fast cycles: the low half and its carry come first, the high half follows using that saved carry, and the condition flags are formed in a third cycle once both halves exist. Only one 16-bit adder plus its operand multiplexers sits in any single fast cycle.

A new operation may be issued every fast cycle. Each operand half may be taken from the register-file input or bypassed from the most recent valid result, and the two halves are selected on their own. The low half of a producer is ready for a dependent consumer in the very next cycle, and the producer's high half arrives one cycle later, exactly when the consumer's high-half stage needs it. Fully dependent operations therefore chain at one fast cycle each, which is two per main clock when the fast clock runs at twice the main rate. Shifts, multiply, divide and branch resolution belong to slower units and are not part of this block.

Top module: `staggered_alu`

## Requirements
- R1: With op code 0 (ADD) the result is A + B modulo 2^32; the carry flag is the carry out of bit 31.
- R2: With op code 1 (SUB) the result is A - B modulo 2^32; the carry flag is 1 when A >= B as unsigned numbers (no borrow) and 0 otherwise.
- R3: With op codes 2 (AND), 3 (OR) and 4 (XOR) the result is the bitwise function of A and B, and the carry and overflow flags are 0.
- R4: An operation issued with `issue_valid` high at clock edge k appears on `result`/`flags` with `res_valid` high after edge k+2; one operation may be issued on every edge.
- R5: `flags` is {Z, N, C, V} in bits 3..0: Z is 1 when the 32-bit result is zero, N is result bit 31, V is signed two's-complement overflow for ADD and SUB.
- R6: A cycle without an issue (bubble) produces `res_valid` low two edges later, and `result` and `flags` keep their previous values.
- R7: `byp_a[0]` / `byp_b[0]` replace bits 15:0 of A / B with bits 15:0 of the most recent valid result, so a fully dependent operation can issue in the cycle right after its producer.
- R8: `byp_a[1]` / `byp_b[1]` replace bits 31:16 of A / B with bits 31:16 of the most recent valid result, independently of the low-half select.
- R9: The carry out of bit 15 computed in the low-half cycle feeds the high half of the same operation (for example 0x0000FFFF + 1 = 0x00010000).
- R10: While `rst_n` is low and after its release, `res_valid`, `result` and `flags` are all zero until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast ALU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| op | input | 3 | Operation code: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR |
| a_rf | input | 32 | Operand A from the register file |
| b_rf | input | 32 | Operand B from the register file |
| byp_a | input | 2 | Bypass select for A: bit 0 low half, bit 1 high half |
| byp_b | input | 2 | Bypass select for B: bit 0 low half, bit 1 high half |
| res_valid | output | 1 | `result` and `flags` hold a new operation's outcome |
| result | output | 32 | 32-bit result |
| flags | output | 4 | {Z, N, C, V} |

## Verification
A wrong carry saved between the half cycles shows as a high half off by one on the very next valid result, and a wrong stage valid shows as a missing or extra `res_valid` pulse within three edges of the issue. A stale or misrouted bypass register does not stay hidden: the bench keeps dependent chains running back to back with mixed low and high selects, so a bad half reaches `result` one or two operations later and keeps propagating. Flag errors surface on the same edge as the result, since every valid output is compared against a behavioural model of the full 32-bit operation.

// File: rtl/staggered_alu_pkg.sv
package staggered_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic logic op_is_logic(alu_op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
  endfunction

endpackage

// File: rtl/sa_half_slice.sv
module sa_half_slice
  import staggered_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout,
  output logic         ovf,
  output logic         zero
);

  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  always_comb begin
    b_eff = (op == OP_SUB) ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    cout  = 1'b0;
    ovf   = 1'b0;
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: begin
        y    = sum[W-1:0];
        cout = sum[W];
        ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
      end
    endcase
    zero = (y == '0);
  end

endmodule

// File: rtl/sa_flag_pack.sv
module sa_flag_pack
  import staggered_alu_pkg::*;
(
  input  alu_op_e    op,
  input  logic       zero_lo,
  input  logic       zero_hi,
  input  logic       msb,
  input  logic       carry,
  input  logic       ovf,
  output alu_flags_t flags
);

  always_comb begin
    flags.z = zero_lo & zero_hi;
    flags.n = msb;
    flags.c = op_is_logic(op) ? 1'b0 : carry;
    flags.v = op_is_logic(op) ? 1'b0 : ovf;
  end

endmodule

// File: rtl/staggered_alu.sv
module staggered_alu
  import staggered_alu_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_valid,
  input  logic [2:0]            op,
  input  logic [2*HALF_W-1:0]   a_rf,
  input  logic [2*HALF_W-1:0]   b_rf,
  input  logic [1:0]            byp_a,
  input  logic [1:0]            byp_b,
  output logic                  res_valid,
  output logic [2*HALF_W-1:0]   result,
  output logic [3:0]            flags
);

  localparam int W = 2 * HALF_W;

  // stage 1: low half
  logic              s1_valid_q;
  alu_op_e           s1_op_q;
  logic [HALF_W-1:0] s1_lo_q, s1_ahi_q, s1_bhi_q;
  logic              s1_carry_q, s1_zlo_q;
  logic [1:0]        s1_hsel_q;
  // stage 2: high half
  logic              s2_valid_q;
  alu_op_e           s2_op_q;
  logic [HALF_W-1:0] s2_lo_q, s2_hi_q;
  logic              s2_carry_q, s2_ovf_q, s2_zlo_q, s2_zhi_q;
  // stage 3: flags and output
  logic              s3_valid_q;
  alu_op_e           s3_op_q;
  logic [W-1:0]      s3_res_q;
  alu_flags_t        s3_flags_q;

  // next-state signals
  alu_op_e           op_in;
  logic [HALF_W-1:0] lo_a, lo_b, lo_y, hi_a, hi_b, hi_y;
  logic              lo_cin, lo_cout, lo_ovf, lo_zero;
  logic              hi_cout, hi_ovf, hi_zero;
  alu_flags_t        flags_d;

  always_comb begin
    op_in  = alu_op_e'(op);
    lo_a   = byp_a[0] ? s1_lo_q : a_rf[HALF_W-1:0];
    lo_b   = byp_b[0] ? s1_lo_q : b_rf[HALF_W-1:0];
    lo_cin = (op_in == OP_SUB);
    hi_a   = s1_hsel_q[0] ? s2_hi_q : s1_ahi_q;
    hi_b   = s1_hsel_q[1] ? s2_hi_q : s1_bhi_q;
  end

  sa_half_slice #(.W(HALF_W)) u_lo (
    .op(op_in), .a(lo_a), .b(lo_b), .cin(lo_cin),
    .y(lo_y), .cout(lo_cout), .ovf(lo_ovf), .zero(lo_zero)
  );

  sa_half_slice #(.W(HALF_W)) u_hi (
    .op(s1_op_q), .a(hi_a), .b(hi_b), .cin(s1_carry_q),
    .y(hi_y), .cout(hi_cout), .ovf(hi_ovf), .zero(hi_zero)
  );

  sa_flag_pack u_flags (
    .op(s2_op_q), .zero_lo(s2_zlo_q), .zero_hi(s2_zhi_q),
    .msb(s2_hi_q[HALF_W-1]), .carry(s2_carry_q), .ovf(s2_ovf_q),
    .flags(flags_d)
  );

  // valid chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s3_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= issue_valid;
      s2_valid_q <= s1_valid_q;
      s3_valid_q <= s2_valid_q;
    end
  end

  // stage 1 registers, enabled by issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q    <= OP_ADD;
      s1_lo_q    <= '0;
      s1_ahi_q   <= '0;
      s1_bhi_q   <= '0;
      s1_carry_q <= 1'b0;
      s1_zlo_q   <= 1'b0;
      s1_hsel_q  <= '0;
    end else if (issue_valid) begin
      s1_op_q    <= op_in;
      s1_lo_q    <= lo_y;
      s1_ahi_q   <= a_rf[W-1:HALF_W];
      s1_bhi_q   <= b_rf[W-1:HALF_W];
      s1_carry_q <= lo_cout;
      s1_zlo_q   <= lo_zero;
      s1_hsel_q  <= {byp_b[1], byp_a[1]};
    end
  end

  // stage 2 registers, enabled by stage-1 valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op_q    <= OP_ADD;
      s2_lo_q    <= '0;
      s2_hi_q    <= '0;
      s2_carry_q <= 1'b0;
      s2_ovf_q   <= 1'b0;
      s2_zlo_q   <= 1'b0;
      s2_zhi_q   <= 1'b0;
    end else if (s1_valid_q) begin
      s2_op_q    <= s1_op_q;
      s2_lo_q    <= s1_lo_q;
      s2_hi_q    <= hi_y;
      s2_carry_q <= hi_cout;
      s2_ovf_q   <= hi_ovf;
      s2_zlo_q   <= s1_zlo_q;
      s2_zhi_q   <= hi_zero;
    end
  end

  // stage 3 registers, enabled by stage-2 valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_op_q    <= OP_ADD;
      s3_res_q   <= '0;
      s3_flags_q <= '0;
    end else if (s2_valid_q) begin
      s3_op_q    <= s2_op_q;
      s3_res_q   <= {s2_hi_q, s2_lo_q};
      s3_flags_q <= flags_d;
    end
  end

  assign res_valid = s3_valid_q;
  assign result    = s3_res_q;
  assign flags     = s3_flags_q;

  // ---------------- assertions ----------------
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_ISSUE_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (res_valid == $past(issue_valid, 3))); // R4

  AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(flags) && $stable(result))); // R6

  AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_is_logic(s3_op_q)) |-> (flags[1:0] == 2'b00)); // R3

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags[3] == (result == '0))); // R5

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags[2] == result[W-1])); // R5

endmodule

// File: tb/tb_staggered_alu.sv
`timescale 1ns/1ps
module tb_staggered_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [2:0]  op;
  logic [31:0] a_rf, b_rf;
  logic [1:0]  byp_a, byp_b;
  logic        res_valid;
  logic [31:0] result;
  logic [3:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  staggered_alu dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op(op),
    .a_rf(a_rf), .b_rf(b_rf), .byp_a(byp_a), .byp_b(byp_b),
    .res_valid(res_valid), .result(result), .flags(flags)
  );

  // reference model state
  logic [31:0] last_res = 32'h0;   // most recent valid result
  logic [31:0] out_res  = 32'h0;   // expected held output
  logic [3:0]  out_flg  = 4'h0;
  logic        pv[3];
  logic [31:0] pr[3];
  logic [3:0]  pf[3];
  string       pt[3];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    if (pv[2]) begin
      out_res = pr[2];
      out_flg = pf[2];
    end
    chk({pt[2], "/R4 valid"}, {31'd0, res_valid}, {31'd0, pv[2]});
    chk(pv[2] ? {pt[2], " result"} : "R6 held result", result, out_res);
    chk(pv[2] ? {pt[2], "/R5 flags"} : "R6 held flags", {28'd0, flags}, {28'd0, out_flg});
  endtask

  function automatic void model(input logic v, input logic [2:0] o,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [1:0] sa, input logic [1:0] sb,
                                input string tag);
    logic [31:0] ea, eb, r;
    logic [32:0] wide;
    logic c, ov;
    ea = {sa[1] ? last_res[31:16] : a[31:16], sa[0] ? last_res[15:0] : a[15:0]};
    eb = {sb[1] ? last_res[31:16] : b[31:16], sb[0] ? last_res[15:0] : b[15:0]};
    c = 0; ov = 0;
    case (o)
      3'd1: begin
        r  = ea - eb;
        c  = (ea >= eb);
        ov = (ea[31] != eb[31]) && (r[31] != ea[31]);
      end
      3'd2: r = ea & eb;
      3'd3: r = ea | eb;
      3'd4: r = ea ^ eb;
      default: begin
        wide = {1'b0, ea} + {1'b0, eb};
        r  = wide[31:0];
        c  = wide[32];
        ov = (ea[31] == eb[31]) && (r[31] != ea[31]);
      end
    endcase
    pv[2] = pv[1]; pr[2] = pr[1]; pf[2] = pf[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pr[1] = pr[0]; pf[1] = pf[0]; pt[1] = pt[0];
    pv[0] = v; pr[0] = r; pf[0] = {(r == 0), r[31], c, ov}; pt[0] = tag;
    if (v) last_res = r;
  endfunction

  // one fast cycle: check outputs of last edge, then drive the next issue
  task automatic cyc(logic v, logic [2:0] o, logic [31:0] a, logic [31:0] b,
                     logic [1:0] sa, logic [1:0] sb, string tag);
    @(negedge clk);
    compare();
    issue_valid = v; op = o; a_rf = a; b_rf = b; byp_a = sa; byp_b = sb;
    model(v, o, a, b, sa, sb, tag);
  endtask

  task automatic bubble(); cyc(1'b0, 3'd0, 32'hDEAD_BEEF, 32'h1234_5678, 2'b11, 2'b11, "R6"); endtask

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 0; pr[i] = 0; pf[i] = 0; pt[i] = "R6"; end
    rst_n = 0; issue_valid = 0; op = 0; a_rf = 0; b_rf = 0; byp_a = 0; byp_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 valid",  {31'd0, res_valid}, 32'd0);
    chk("R10 result", result, 32'd0);
    chk("R10 flags",  {28'd0, flags}, 32'd0);
    rst_n = 1;

    // R1 adds, R9 carry across halves, R5 zero/overflow
    cyc(1, 3'd0, 32'h0000_0003, 32'h0000_0004, 2'b00, 2'b00, "R1");
    cyc(1, 3'd0, 32'h0000_FFFF, 32'h0000_0001, 2'b00, 2'b00, "R9");
    cyc(1, 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 2'b00, 2'b00, "R5 ovf");
    cyc(1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 2'b00, "R5 zero carry");
    // R2 subtract
    cyc(1, 3'd1, 32'h0000_0010, 32'h0000_0003, 2'b00, 2'b00, "R2 noborrow");
    cyc(1, 3'd1, 32'h0000_0003, 32'h0000_0010, 2'b00, 2'b00, "R2 borrow");
    cyc(1, 3'd1, 32'h8000_0000, 32'h0000_0001, 2'b00, 2'b00, "R2 ovf");
    cyc(1, 3'd1, 32'h1234_5678, 32'h1234_5678, 2'b00, 2'b00, "R2 zero");
    // R3 logic
    cyc(1, 3'd2, 32'hF0F0_FFFF, 32'hFF00_0001, 2'b00, 2'b00, "R3 and");
    cyc(1, 3'd3, 32'h8000_0000, 32'h0000_0001, 2'b00, 2'b00, "R3 or");
    cyc(1, 3'd4, 32'hAAAA_5555, 32'hAAAA_5555, 2'b00, 2'b00, "R3 xor");
    bubble(); bubble();
    // R7 low-half bypass chain, back to back
    cyc(1, 3'd0, 32'h0001_8000, 32'h0002_8000, 2'b00, 2'b00, "R7 seed");
    cyc(1, 3'd0, 32'h1111_0000, 32'h0000_0001, 2'b01, 2'b00, "R7 lo A");
    cyc(1, 3'd1, 32'h0000_0005, 32'h2222_0000, 2'b00, 2'b01, "R7 lo B");
    // R8 high-half bypass alone and mixed
    cyc(1, 3'd0, 32'h0000_0007, 32'h0000_0009, 2'b10, 2'b00, "R8 hi A");
    cyc(1, 3'd3, 32'h5555_0000, 32'h0000_00F0, 2'b00, 2'b10, "R8 hi B");
    cyc(1, 3'd0, 32'h0000_0000, 32'h0000_0000, 2'b11, 2'b11, "R8 full dep");
    cyc(1, 3'd4, 32'h0000_FFFF, 32'hFFFF_0000, 2'b01, 2'b10, "R8 mixed");
    // R6 bubble then dependent op uses last valid result
    bubble();
    cyc(1, 3'd1, 32'h0, 32'h0000_0001, 2'b11, 2'b00, "R6 after bubble");
    bubble(); bubble(); bubble();
    // mixed random stream
    for (int k = 0; k < 400; k++)
      cyc($urandom_range(0, 3) != 0, 3'($urandom_range(0, 4)), $urandom, $urandom,
          2'($urandom), 2'($urandom), "R1/R2/R3/R7/R8 rnd");
    bubble(); bubble(); bubble(); bubble();
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule